// File: doc/BRIEF.md
# Timestamped Edge Capture Unit

This block watches a small group of digital input lines and records when they change. A free-running 16-bit reference timer advances once per eight clock cycles. Whenever an enabled line shows an edge that meets its configured rule, the unit produces an entry. An entry holds the timer value of that tick and a bitmap naming every line that qualified during the tick. Entries queue in a FIFO behind a single holding register. The holding register is presented to the consumer as a valid/ready stream.

Each line has its own mode and enable, written through a plain configuration strobe. The available rules are rising edge, falling edge, either edge, and every eighth rising edge. One interrupt pulse is produced. It marks either the arrival of an entry in the holding register or the loading of the sixth entry into the FIFO, chosen by a select pin. When all storage is full, new entries are dropped and a sticky overflow flag is set.

Stream rules: `hold_valid` stays high and `hold_time`/`hold_lines` stay unchanged until a cycle with `hold_ready` high. That handshake cycle removes the entry. The oldest FIFO entry moves up on the same clock edge. The consumer may hold `hold_ready` low for any length of time. During that time the FIFO keeps filling until it is full.

Top module: `evcap_top`

## Requirements
- R1: After reset `tmr_now` is 0 and increases by exactly 1 (wrapping at 16 bits) once every 8 clock cycles.
- R2: A line in mode 0 (rising) produces an entry for a low-to-high transition and none for a high-to-low transition.
- R3: A line in mode 1 (falling) produces an entry for a high-to-low transition and none for a low-to-high transition.
- R4: A line in mode 2 (both) produces one entry for each transition when the transitions fall in different timer ticks.
- R5: A line in mode 3 produces an entry on every eighth rising edge only. Writing the line's configuration clears its edge count to zero.
- R6: A line whose enable bit is 0 produces no entries.
- R7: Qualifying edges on several lines in the same timer tick produce one entry. Its `hold_lines` has bit i set for each line i that fired, and its `hold_time` is that tick's timer value.
- R8: Entries leave in arrival order. While `hold_valid` is high and `hold_ready` is low, the entry is held unchanged. A handshake removes it.
- R9: At most 8 entries are held (7 in the FIFO plus the holding register). An entry arriving when all 8 are held is dropped, and `overflow` rises and stays high until reset.
- R10: With `irq_sel` = 0, `irq` pulses for one cycle each time an entry is loaded into the holding register.
- R11: With `irq_sel` = 1, `irq` pulses for one cycle when an entry raises the FIFO occupancy to 6, and at no other time.
- R12: After reset `hold_valid`, `irq` and `overflow` are 0, and all lines are disabled in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lines_in | input | 4 | Asynchronous input lines |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Line selected by the write |
| cfg_mode | input | 2 | Edge mode: 0 rising, 1 falling, 2 both, 3 every eighth rising |
| cfg_en | input | 1 | Enable for the selected line |
| irq_sel | input | 1 | 0: interrupt on holding load, 1: interrupt on sixth FIFO entry |
| tmr_now | output | 16 | Current reference timer value |
| hold_valid | output | 1 | Holding register holds an entry |
| hold_ready | input | 1 | Consumer accepts the entry |
| hold_time | output | 16 | Timestamp of the held entry |
| hold_lines | output | 4 | Bitmap of lines in the held entry |
| irq | output | 1 | One-cycle interrupt pulse |
| overflow | output | 1 | Sticky entry-drop flag |

## Verification
Single pulses are applied in each mode. A rising-only stimulus and a falling-only stimulus separate the rising, falling and both-edge rules. Bursts of seven and eight rising edges show whether the eighth-edge rule counts exactly, and a configuration write in the middle of a burst shows that the count is cleared. Two lines pulsed in the same tick must give one merged entry, which separates merging from per-line queuing. A long stall with nine events exercises ordering, the sixth-entry interrupt, the eight-entry limit and the sticky drop flag.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
  typedef enum logic [1:0] {
    EM_RISE   = 2'd0,
    EM_FALL   = 2'd1,
    EM_BOTH   = 2'd2,
    EM_EIGHTH = 2'd3
  } edge_mode_e;
endpackage

// File: rtl/evcap_line.sv
module evcap_line
  import evcap_pkg::*;
#(
  parameter int DIV_EDGES = 8,
  localparam int DC_W = $clog2(DIV_EDGES)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic       wr_i,
  input  logic [1:0] mode_i,
  input  logic       en_i,
  output logic       ev_o
);
  logic [1:0]    sync_q;
  logic          prv_q;
  edge_mode_e    mode_q;
  logic          en_q;
  logic [DC_W-1:0] cnt_q;
  logic          ev_q;
  logic          rise, fall, hit, last_edge;

  assign rise      = sync_q[1] & ~prv_q;
  assign fall      = ~sync_q[1] & prv_q;
  assign last_edge = (cnt_q == DC_W'(DIV_EDGES - 1));

  always_comb begin
    case (mode_q)
      EM_RISE:   hit = rise;
      EM_FALL:   hit = fall;
      EM_BOTH:   hit = rise | fall;
      default:   hit = rise & last_edge;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prv_q  <= 1'b0;
      mode_q <= EM_RISE;
      en_q   <= 1'b0;
      cnt_q  <= '0;
      ev_q   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      prv_q  <= sync_q[1];
      ev_q   <= en_q & hit;
      if (wr_i) begin
        mode_q <= edge_mode_e'(mode_i);
        en_q   <= en_i;
        cnt_q  <= '0;
      end else if (en_q && mode_q == EM_EIGHTH && rise) begin
        cnt_q <= last_edge ? '0 : cnt_q + 1'b1;
      end
    end
  end

  assign ev_o = ev_q;

  // R6
  line_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_q |-> $past(en_q));
  // R5
  line_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> cnt_q == '0);
endmodule

// File: rtl/evcap_fifo.sv
module evcap_fifo #(
  parameter int WIDTH = 20,
  parameter int DEPTH = 7,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic [CNT_W-1:0] count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (pop_i)  rp_q <= nxt(rp_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout_o  = mem_q[rp_q];
  assign count_o = cnt_q;

  // R9
  fifo_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> cnt_q < CNT_W'(DEPTH));
  // R8
  fifo_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> cnt_q != '0);
endmodule

// File: rtl/evcap_top.sv
module evcap_top
  import evcap_pkg::*;
#(
  parameter int N_LINES    = 4,
  parameter int TS_W       = 16,
  parameter int PRESCALE   = 8,
  parameter int FIFO_DEPTH = 7,
  parameter int IRQ_LEVEL  = 6,
  parameter int DIV_EDGES  = 8,
  localparam int SEL_W = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines_in,
  input  logic               cfg_wr,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [1:0]         cfg_mode,
  input  logic               cfg_en,
  input  logic               irq_sel,
  output logic [TS_W-1:0]    tmr_now,
  output logic               hold_valid,
  input  logic               hold_ready,
  output logic [TS_W-1:0]    hold_time,
  output logic [N_LINES-1:0] hold_lines,
  output logic               irq,
  output logic               overflow
);
  localparam int PS_W  = $clog2(PRESCALE);
  localparam int ENT_W = TS_W + N_LINES;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [PS_W-1:0]    pre_q;
  logic [TS_W-1:0]    tmr_q;
  logic               tick;
  logic [N_LINES-1:0] ev_vec, pend_q, ent_lines;
  logic               push_req, push_ok, load, pop;
  logic [ENT_W-1:0]   f_dout;
  logic [CNT_W-1:0]   f_cnt;
  logic [CNT_W:0]     f_after;
  logic               hold_v_q, irq_q, ovf_q;
  logic [ENT_W-1:0]   hold_q;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    evcap_line #(.DIV_EDGES(DIV_EDGES)) i_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (lines_in[i]),
      .wr_i   (cfg_wr && cfg_sel == SEL_W'(i)),
      .mode_i (cfg_mode),
      .en_i   (cfg_en),
      .ev_o   (ev_vec[i])
    );
  end

  assign tick = (pre_q == PS_W'(PRESCALE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      tmr_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) tmr_q <= tmr_q + 1'b1;
    end
  end

  assign ent_lines = pend_q | ev_vec;
  assign push_req  = tick && (ent_lines != '0);
  assign push_ok   = push_req && (f_cnt < CNT_W'(FIFO_DEPTH));
  assign pop       = hold_v_q && hold_ready;
  assign load      = (f_cnt != '0) && (!hold_v_q || pop);
  assign f_after   = {1'b0, f_cnt} + {{CNT_W{1'b0}}, push_ok}
                   - {{CNT_W{1'b0}}, load};

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= tick ? '0 : ent_lines;
  end

  evcap_fifo #(.WIDTH(ENT_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_ok),
    .din_i   ({tmr_q, ent_lines}),
    .pop_i   (load),
    .dout_o  (f_dout),
    .count_o (f_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v_q <= 1'b0;
      hold_q   <= '0;
      irq_q    <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      if (load) begin
        hold_v_q <= 1'b1;
        hold_q   <= f_dout;
      end else if (pop) begin
        hold_v_q <= 1'b0;
      end
      irq_q <= irq_sel ? (push_ok && f_after == (CNT_W+1)'(IRQ_LEVEL)) : load;
      if (push_req && !push_ok) ovf_q <= 1'b1;
    end
  end

  assign tmr_now    = tmr_q;
  assign hold_valid = hold_v_q;
  assign hold_time  = hold_q[ENT_W-1 -: TS_W];
  assign hold_lines = hold_q[N_LINES-1:0];
  assign irq        = irq_q;
  assign overflow   = ovf_q;

  // R1
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_q != $past(tmr_q)) |-> tmr_q == TS_W'($past(tmr_q) + 1'b1));
  // R8
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v_q && !hold_ready) |=> (hold_v_q && $stable(hold_q)));
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !$past(irq_sel)) |-> hold_v_q);
endmodule

// File: tb/test_evcap_top.sv
module test_evcap_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  lines_in = '0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [1:0]  cfg_mode = '0;
  logic        cfg_en = 1'b0;
  logic        irq_sel = 1'b0;
  logic        hold_ready = 1'b0;
  logic [15:0] tmr_now, hold_time;
  logic        hold_valid, irq, overflow;
  logic [3:0]  hold_lines;
  int checks = 0, errors = 0, irq_cnt = 0;

  always #10 clk = ~clk;

  evcap_top i_evcap_top (
    .clk(clk), .rst_n(rst_n), .lines_in(lines_in),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_mode(cfg_mode), .cfg_en(cfg_en),
    .irq_sel(irq_sel), .tmr_now(tmr_now), .hold_valid(hold_valid),
    .hold_ready(hold_ready), .hold_time(hold_time), .hold_lines(hold_lines),
    .irq(irq), .overflow(overflow)
  );

  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    report();
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int ln, input int md, input bit en);
    @(negedge clk);
    cfg_wr = 1; cfg_sel = 2'(ln); cfg_mode = 2'(md); cfg_en = en;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic at_tick(output logic [15:0] ts);
    logic [15:0] t0;
    @(negedge clk);
    t0 = tmr_now;
    while (tmr_now == t0) @(negedge clk);
    ts = tmr_now;
  endtask

  task automatic set_at_tick(input logic [3:0] mask, input bit val, output logic [15:0] ts);
    at_tick(ts);
    if (val) lines_in = lines_in | mask; else lines_in = lines_in & ~mask;
  endtask

  task automatic pulse(input logic [3:0] mask, output logic [15:0] ts);
    at_tick(ts);
    lines_in = lines_in | mask;
    cyc(2);
    lines_in = lines_in & ~mask;
  endtask

  task automatic burst(input logic [3:0] mask, input int n);
    repeat (n) begin
      lines_in = lines_in | mask; cyc(2);
      lines_in = lines_in & ~mask; cyc(2);
    end
    cyc(24);
  endtask

  task automatic pop_check(input logic [15:0] ets, input logic [3:0] eln, input string tag);
    int w = 0;
    while (!hold_valid && w < 40) begin @(negedge clk); w++; end
    chk(hold_valid, {tag, " valid"}, int'(hold_valid), 1);
    chk(hold_time == ets, {tag, " time"}, int'(hold_time), int'(ets));
    chk(hold_lines == eln, {tag, " lines"}, int'(hold_lines), int'(eln));
    hold_ready = 1;
    @(negedge clk);
    hold_ready = 0;
  endtask

  task automatic expect_empty(input string tag);
    cyc(24);
    chk(!hold_valid, {tag, " no entry"}, int'(hold_valid), 0);
  endtask

  task automatic t_reset();
    int n = 0;
    logic [15:0] t0;
    chk(!hold_valid && !irq && !overflow, "R12 reset outputs",
        int'({hold_valid, irq, overflow}), 0);
    chk(tmr_now == 0, "R1 timer at reset", int'(tmr_now), 0);
    lines_in = 4'hF; cyc(40); lines_in = 4'h0;
    expect_empty("R12 lines disabled after reset");
    at_tick(t0);
    t0 = tmr_now;
    while (tmr_now == t0) begin @(negedge clk); n++; end
    chk(n == 8, "R1 tick period", n, 8);
    chk(tmr_now == 16'(t0 + 1), "R1 timer step", int'(tmr_now), int'(t0) + 1);
  endtask

  task automatic t_rise();
    logic [15:0] ts;
    cfg(0, 0, 1);
    pulse(4'b0001, ts);
    pop_check(ts, 4'b0001, "R2 rising pulse");
    expect_empty("R2 falling edge ignored");
  endtask

  task automatic t_fall();
    logic [15:0] ts;
    cfg(1, 1, 1);
    set_at_tick(4'b0010, 1, ts);
    expect_empty("R3 rising edge ignored");
    set_at_tick(4'b0010, 0, ts);
    pop_check(ts, 4'b0010, "R3 falling edge");
    cfg(1, 1, 0);
  endtask

  task automatic t_both();
    logic [15:0] t1, t2;
    cfg(2, 2, 1);
    set_at_tick(4'b0100, 1, t1);
    set_at_tick(4'b0100, 0, t2);
    pop_check(t1, 4'b0100, "R4 rise entry");
    pop_check(t2, 4'b0100, "R4 fall entry");
    expect_empty("R4 two entries only");
    cfg(2, 2, 0);
  endtask

  task automatic t_eighth();
    cfg(3, 3, 1);
    burst(4'b1000, 7);
    chk(!hold_valid, "R5 seven edges no entry", int'(hold_valid), 0);
    burst(4'b1000, 1);
    chk(hold_valid && hold_lines == 4'b1000, "R5 eighth edge entry",
        int'(hold_lines), 8);
    hold_ready = 1; @(negedge clk); hold_ready = 0;
    burst(4'b1000, 5);
    cfg(3, 3, 1);
    burst(4'b1000, 7);
    chk(!hold_valid, "R5 count cleared by write", int'(hold_valid), 0);
    burst(4'b1000, 1);
    chk(hold_valid && hold_lines == 4'b1000, "R5 eighth after clear",
        int'(hold_lines), 8);
    hold_ready = 1; @(negedge clk); hold_ready = 0;
    cfg(3, 3, 0);
  endtask

  task automatic t_disable();
    logic [15:0] ts;
    cfg(0, 0, 0);
    pulse(4'b0001, ts);
    expect_empty("R6 disabled line");
  endtask

  task automatic t_merge();
    logic [15:0] ts;
    cfg(0, 0, 1);
    cfg(1, 0, 1);
    pulse(4'b0011, ts);
    pop_check(ts, 4'b0011, "R7 merged entry");
    expect_empty("R7 single entry");
    cfg(1, 0, 0);
  endtask

  task automatic t_irq_hold();
    logic [15:0] ts;
    irq_sel = 0;
    cyc(2);
    irq_cnt = 0;
    pulse(4'b0001, ts);
    cyc(20);
    chk(irq_cnt == 1, "R10 irq on holding load", irq_cnt, 1);
    hold_ready = 1; @(negedge clk); hold_ready = 0;
    cyc(4);
    chk(irq_cnt == 1, "R10 no irq on pop", irq_cnt, 1);
  endtask

  task automatic t_fill();
    logic [15:0] ts [9];
    irq_sel = 1;
    cyc(2);
    irq_cnt = 0;
    for (int i = 0; i < 6; i++) pulse(4'b0001, ts[i]);
    cyc(12);
    chk(irq_cnt == 0, "R11 no irq at five in fifo", irq_cnt, 0);
    pulse(4'b0001, ts[6]);
    cyc(12);
    chk(irq_cnt == 1, "R11 irq at sixth fifo entry", irq_cnt, 1);
    pulse(4'b0001, ts[7]);
    cyc(12);
    chk(!overflow, "R9 eight held no overflow", int'(overflow), 0);
    chk(hold_valid && hold_time == ts[0], "R8 stalled head kept",
        int'(hold_time), int'(ts[0]));
    pulse(4'b0001, ts[8]);
    cyc(12);
    chk(overflow, "R9 ninth dropped sets flag", int'(overflow), 1);
    chk(irq_cnt == 1, "R11 single irq", irq_cnt, 1);
    for (int i = 0; i < 8; i++) pop_check(ts[i], 4'b0001, "R8 order");
    expect_empty("R9 ninth entry absent");
    chk(overflow, "R9 flag sticky", int'(overflow), 1);
  endtask

  initial begin
    cyc(5);
    rst_n = 1;
    cyc(2);
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_eighth();
    t_disable();
    t_merge();
    t_irq_hold();
    t_fill();
    report();
  end
endmodule